// File: doc/BRIEF.md
# Multi-Mode Serial Receive Engine

This block turns a sampled serial input into parallel words. Each completed frame loads a receive data register and raises a data-ready flag. The same cycle also records parity, overrun and framing errors. An interrupt output is high while the enable is set and any of those flags is set. Software-side logic reads the word with a read strobe and clears the error flags with a separate clear strobe. Baud generation, transmission and bus decoding are outside the block.

Four operating modes are selected by `mode`:
- 0: plain asynchronous.
- 1: asynchronous multiprocessor, with an address/data bit after the data.
- 2: clocked synchronous, where each `smp_tick` is one serial clock edge and start/stop framing is optional.
- 3: asynchronous line-bus framing, which behaves as 8 data bits and one stop bit with no parity.

In the asynchronous modes `smp_tick` runs at `OVS` pulses per bit. A start bit is confirmed at mid-bit, and every later bit is sampled at its own middle.

Top module: `serial_rx_unit`

## Requirements
- R1: In modes 0 and 3 with `par_fmt`=0, a low start bit that is still low at the 2nd tick of the bit is followed by `DW` data bits sampled LSB first and one stop bit. Sampling the stop bit loads `rx_data` and sets `rdy`.
- R2: In mode 0 with `par_fmt`=1, the frame carries `DW-1` data bits and then a parity bit in the last data slot. `rx_data` holds the data bits with its MSB at 0. `pe` is set when the total count of ones in data plus parity is odd and `par_odd`=0, or even and `par_odd`=1.
- R3: `pe` never becomes set in modes 1, 2 and 3, whatever `par_fmt` is.
- R4: In mode 1, one extra bit after the data bits and before the stop bit is latched to `ad_bit` together with `rx_data`. In the other modes `ad_bit` is loaded with 0.
- R5: A stop bit sampled at 0 sets `fre` and still loads the word and sets `rdy`. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: In mode 2 with `sync_frm`=1, each tick samples one bit. A 0 starts the frame, `DW` data bits follow LSB first, and the stop-bit tick loads the word.
- R7: In mode 2 with `sync_frm`=0, every `DW` ticks form one word, LSB first. The word is loaded on its last data bit with no stop bit, and `fre` is never set.
- R8: `ore` is set when a frame completes while `rdy` is still 1 and no read strobe comes in that cycle. The new word replaces the old one.
- R9: `rd_strobe` clears `rdy` but leaves the error flags alone. `err_clr` clears `pe`, `ore` and `fre`.
- R10: `irq` is 1 exactly when `rie`=1 and at least one of `rdy`, `pe`, `ore`, `fre` is 1.
- R11: In the asynchronous modes, a start bit that is high again by its 2nd tick is discarded, and no word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_line | input | 1 | Synchronised serial input |
| smp_tick | input | 1 | Sample strobe (OVS per bit async, one per bit in mode 2) |
| mode | input | 2 | Operating mode 0..3 |
| par_fmt | input | 1 | Mode 0: last data slot is parity |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| sync_frm | input | 1 | Mode 2: start/stop framing on |
| rie | input | 1 | Reception interrupt enable |
| rd_strobe | input | 1 | Data register read |
| err_clr | input | 1 | Clear error flags |
| rx_data | output | DW | Receive data register |
| rdy | output | 1 | Data ready |
| pe | output | 1 | Parity error |
| ore | output | 1 | Overrun error |
| fre | output | 1 | Framing error |
| ad_bit | output | 1 | Latched address/data bit |
| irq | output | 1 | Reception interrupt |

## Verification
A mis-timed sampling counter shows at the ports as a word shifted by one bit, or as a spurious `fre`, as soon as the first frame ends. A wrong frame-state transition shows up quickly too. It leaves `rdy` low after a full frame, or loads a word in the wrong place when the synchronous unframed mode runs back-to-back words. Flag bookkeeping errors appear within one frame as `ore` missing or spurious across unread pairs, as `pe` showing in a mode where it must stay 0, or as `irq` disagreeing with the enable and the flags.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_START, S_DATA, S_STOP, S_HOLD
   } srx_state_t;

   localparam logic [1:0] MD_PLAIN = 2'd0;
   localparam logic [1:0] MD_MPROC = 2'd1;
   localparam logic [1:0] MD_SYNC  = 2'd2;
   localparam logic [1:0] MD_LBUS  = 2'd3;
endpackage

// File: rtl/srx_timer.sv
module srx_timer
   import srx_pkg::*;
#(
   parameter int OVS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       sync,
   input  srx_state_t st,
   output logic       start_chk,
   output logic       bit_stb
);
   localparam int CNW  = $clog2(OVS);
   localparam int CONF = OVS / 2 - 2;

   logic [CNW-1:0] cnt;
   logic           in_start, in_frame;

   assign in_start  = (st == S_START);
   assign in_frame  = (st == S_DATA) || (st == S_STOP);
   assign start_chk = tick && in_start && (cnt == CNW'(CONF));
   assign bit_stb   = sync ? tick
                           : (tick && in_frame && (cnt == CNW'(OVS - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (sync || !(in_start || in_frame)) begin
         cnt <= '0;
      end else if (tick) begin
         if (in_start)
            cnt <= (cnt == CNW'(CONF)) ? '0 : cnt + 1'b1;
         else
            cnt <= (cnt == CNW'(OVS - 1)) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line,
   input  logic          tick,
   input  logic          sync,
   input  logic          framed,
   input  logic          mproc,
   input  logic          start_chk,
   input  logic          bit_stb,
   output srx_state_t    st,
   output logic          done,
   output logic [DW-1:0] word,
   output logic          adr,
   output logic          ferr
);
   localparam int CW = $clog2(DW + 2);

   logic [DW:0]   shreg;
   logic [CW-1:0] bitcnt;
   logic [CW-1:0] last_idx;
   logic          raw;

   assign raw      = sync && !framed;
   assign last_idx = mproc ? CW'(DW) : CW'(DW - 1);
   assign word     = mproc ? shreg[DW-1:0] : shreg[DW:1];
   assign adr      = mproc ? shreg[DW] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         shreg  <= '0;
         bitcnt <= '0;
         done   <= 1'b0;
         ferr   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (tick) begin
               if (raw) begin
                  shreg  <= {line, shreg[DW:1]};
                  bitcnt <= CW'(1);
                  st     <= S_DATA;
               end else if (!line) begin
                  bitcnt <= '0;
                  st     <= sync ? S_DATA : S_START;
               end
            end
            S_START: if (start_chk) st <= line ? S_IDLE : S_DATA;
            S_DATA: if (bit_stb) begin
               shreg <= {line, shreg[DW:1]};
               if (bitcnt == last_idx) begin
                  if (raw) begin
                     done <= 1'b1;
                     ferr <= 1'b0;
                     st   <= S_IDLE;
                  end else begin
                     st <= S_STOP;
                  end
               end else begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
            S_STOP: if (bit_stb) begin
               done <= 1'b1;
               ferr <= !line;
               st   <= line ? S_IDLE : S_HOLD;
            end
            S_HOLD: if (tick && line) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
   import srx_pkg::*;
#(
   parameter int DW     = 8,
   parameter bit PAR_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [DW-1:0] word,
   input  logic          adr,
   input  logic          ferr,
   input  logic [1:0]    mode,
   input  logic          par_fmt,
   input  logic          par_odd,
   input  logic          rd,
   input  logic          clr,
   output logic [DW-1:0] data_q,
   output logic          ad_q,
   output logic          rdy_q,
   output logic          pe_q,
   output logic          ore_q,
   output logic          fre_q
);
   logic          perr;
   logic          use_par;
   logic [DW-1:0] load_val;

   assign use_par = (mode == MD_PLAIN) && par_fmt;

   generate
      if (PAR_EN) begin : g_par
         assign perr     = use_par && ((^word) ^ par_odd);
         assign load_val = use_par ? {1'b0, word[DW-2:0]} : word;
      end else begin : g_nopar
         assign perr     = 1'b0;
         assign load_val = word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ad_q   <= 1'b0;
         rdy_q  <= 1'b0;
         pe_q   <= 1'b0;
         ore_q  <= 1'b0;
         fre_q  <= 1'b0;
      end else if (done) begin
         data_q <= load_val;
         ad_q   <= adr;
         rdy_q  <= 1'b1;
         pe_q   <= pe_q | perr;
         ore_q  <= ore_q | (rdy_q & ~rd);
         fre_q  <= fre_q | ferr;
      end else begin
         if (rd) rdy_q <= 1'b0;
         if (clr) begin
            pe_q  <= 1'b0;
            ore_q <= 1'b0;
            fre_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
   import srx_pkg::*;
#(
   parameter int DW     = 8,
   parameter int OVS    = 4,
   parameter bit PAR_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_line,
   input  logic          smp_tick,
   input  logic [1:0]    mode,
   input  logic          par_fmt,
   input  logic          par_odd,
   input  logic          sync_frm,
   input  logic          rie,
   input  logic          rd_strobe,
   input  logic          err_clr,
   output logic [DW-1:0] rx_data,
   output logic          rdy,
   output logic          pe,
   output logic          ore,
   output logic          fre,
   output logic          ad_bit,
   output logic          irq
);
   generate
      if (DW < 5 || DW > 16) begin : g_bad_dw
         $error("serial_rx_unit: DW must be 5..16");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("serial_rx_unit: OVS must be even and at least 4");
      end
   endgenerate

   srx_state_t    st;
   logic          sync, mproc, start_chk, bit_stb, done, adr, ferr;
   logic [DW-1:0] word;

   assign sync  = (mode == MD_SYNC);
   assign mproc = (mode == MD_MPROC);

   srx_timer #(.OVS(OVS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(smp_tick), .sync(sync), .st(st),
      .start_chk(start_chk), .bit_stb(bit_stb)
   );

   srx_frame #(.DW(DW)) u_frame (
      .clk(clk), .rst_n(rst_n), .line(rx_line), .tick(smp_tick), .sync(sync),
      .framed(sync_frm), .mproc(mproc), .start_chk(start_chk),
      .bit_stb(bit_stb), .st(st), .done(done), .word(word), .adr(adr),
      .ferr(ferr)
   );

   srx_flags #(.DW(DW), .PAR_EN(PAR_EN)) u_flags (
      .clk(clk), .rst_n(rst_n), .done(done), .word(word), .adr(adr),
      .ferr(ferr), .mode(mode), .par_fmt(par_fmt), .par_odd(par_odd),
      .rd(rd_strobe), .clr(err_clr), .data_q(rx_data), .ad_q(ad_bit),
      .rdy_q(rdy), .pe_q(pe), .ore_q(ore), .fre_q(fre)
   );

   assign irq = rie & (rdy | pe | ore | fre);
endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       sync_frm,
   input logic       rd_strobe,
   input logic       rdy,
   input logic       pe,
   input logic       ore,
   input logic       fre,
   input logic       done,
   input logic       ferr
);
   // R1
   rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $past(done));

   // R3
   pe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pe) |-> ($past(mode) == 2'd0));

   // R5
   fre_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fre) |-> ($past(done) && $past(ferr)));

   // R7
   fre_unframed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fre) |-> !($past(mode) == 2'd2 && !$past(sync_frm)));

   // R8
   ore_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ore) |-> ($past(rdy) && $past(done)));

   // R9
   rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy) |-> $past(rd_strobe));
endmodule

bind serial_rx_unit serial_rx_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .sync_frm(sync_frm),
   .rd_strobe(rd_strobe), .rdy(rdy), .pe(pe), .ore(ore), .fre(fre),
   .done(done), .ferr(ferr)
);

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;
   localparam int DW  = 8;
   localparam int OVS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_line = 1'b1, smp_tick = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          par_fmt = 1'b0, par_odd = 1'b0, sync_frm = 1'b0, rie = 1'b0;
   logic          rd_strobe = 1'b0, err_clr = 1'b0;
   logic [DW-1:0] rx_data;
   logic          rdy, pe, ore, fre, ad_bit, irq;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   serial_rx_unit #(.DW(DW), .OVS(OVS)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .smp_tick(smp_tick),
      .mode(mode), .par_fmt(par_fmt), .par_odd(par_odd), .sync_frm(sync_frm),
      .rie(rie), .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
      .rdy(rdy), .pe(pe), .ore(ore), .fre(fre), .ad_bit(ad_bit), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) smp_tick = 1'b1;
         @(negedge clk) smp_tick = 1'b0;
      end
   endtask

   task automatic put_bit(input logic b, input int n);
      rx_line = b;
      ticks(n);
   endtask

   // async frame: start, nb bits LSB first, stop, then idle
   task automatic async_frame(input logic [DW:0] bits, input int nb, input logic stop);
      put_bit(1'b0, OVS);
      for (int i = 0; i < nb; i++) put_bit(bits[i], OVS);
      put_bit(stop, OVS);
      put_bit(1'b1, OVS);
   endtask

   task automatic sync_bits(input logic [DW-1:0] d);
      for (int i = 0; i < DW; i++) put_bit(d[i], 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_rd();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk) err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
   endtask

   function automatic logic par_bit(input logic [DW-2:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   function automatic logic exp_irq(input logic en, input logic a, input logic b,
                                    input logic c, input logic d);
      return en & (a | b | c | d);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d, d2;
      logic          ab, pb;
      process::self().srandom(32'h5eed_1234);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(rdy == 0 && pe == 0 && ore == 0 && fre == 0, "R9 reset flags", {rdy, pe, ore, fre}, 0);
      chk(irq == 0 && rx_data == 0, "R10 reset irq/data", {irq, rx_data}, 0);

      // R1 directed 8N1
      rie = 1'b1;
      async_frame({1'b0, 8'hA5}, 8, 1'b1);
      chk(rx_data == 8'hA5, "R1 data", rx_data, 8'hA5);
      chk(rdy == 1 && fre == 0 && pe == 0, "R1 rdy", {rdy, fre, pe}, 4);
      chk(irq == exp_irq(rie, rdy, pe, ore, fre) && irq == 1, "R10 irq on", irq, 1);
      rie = 1'b0;
      @(negedge clk);
      chk(irq == 0, "R10 irq masked", irq, 0);
      rie = 1'b1;
      pulse_rd();
      chk(rdy == 0 && irq == 0, "R9 read clears rdy", {rdy, irq}, 0);

      // random mix of modes 0 (8N1), 1, 3
      for (int it = 0; it < 24; it++) begin
         d  = DW'($urandom);
         ab = 1'($urandom);
         par_fmt = 1'($urandom);
         case ($urandom_range(0, 2))
            0: begin mode = 2'd0; par_fmt = 1'b0; async_frame({1'b0, d}, 8, 1'b1); ab = 1'b0; end
            1: begin mode = 2'd1; async_frame({ab, d}, 9, 1'b1); end
            default: begin mode = 2'd3; async_frame({1'b0, d}, 8, 1'b1); ab = 1'b0; end
         endcase
         chk(rx_data == d && rdy == 1, "R1 random data", rx_data, d);
         chk(ad_bit == ab, "R4 address bit", ad_bit, ab);
         chk(pe == 0 && ore == 0, "R3 no parity error", {pe, ore}, 0);
         pulse_rd();
      end

      // R3: frame with odd bit count in modes 1 and 3 with par_fmt set
      par_fmt = 1'b1;
      mode = 2'd3;
      async_frame({1'b0, 8'h07}, 8, 1'b1);
      chk(pe == 0 && rx_data == 8'h07, "R3 mode3 pe stays 0", {pe, rx_data}, 8'h07);
      pulse_rd();
      mode = 2'd1;
      async_frame({1'b1, 8'h01}, 9, 1'b1);
      chk(pe == 0 && ad_bit == 1, "R3 mode1 pe stays 0", {pe, ad_bit}, 1);
      pulse_rd();

      // R2 parity format: good and bad, even and odd
      mode = 2'd0;
      for (int k = 0; k < 4; k++) begin
         par_odd = k[0];
         d  = DW'($urandom) | 8'h80;
         pb = par_bit(d[6:0], par_odd) ^ k[1];
         async_frame({1'b0, pb, d[6:0]}, 8, 1'b1);
         chk(rx_data == {1'b0, d[6:0]}, "R2 7-bit data", rx_data, {1'b0, d[6:0]});
         chk(pe == k[1], "R2 parity flag", pe, k[1]);
         pulse_rd();
         pulse_clr();
      end
      par_fmt = 1'b0;

      // R5 framing error
      async_frame({1'b0, 8'h3C}, 8, 1'b0);
      chk(fre == 1 && rdy == 1 && rx_data == 8'h3C, "R5 framing error", {fre, rdy, rx_data}, 10'h33C);
      pulse_rd();
      chk(fre == 1, "R9 read keeps fre", fre, 1);
      pulse_clr();
      chk(fre == 0 && irq == 0, "R9 clear drops fre", {fre, irq}, 0);
      async_frame({1'b0, 8'hC3}, 8, 1'b1);
      chk(rx_data == 8'hC3 && fre == 0, "R5 recovery frame", rx_data, 8'hC3);
      pulse_rd();

      // R8 overrun
      d  = DW'($urandom);
      d2 = DW'($urandom);
      async_frame({1'b0, d}, 8, 1'b1);
      chk(ore == 0, "R8 no overrun first", ore, 0);
      async_frame({1'b0, d2}, 8, 1'b1);
      chk(ore == 1 && rx_data == d2 && rdy == 1, "R8 overrun", {ore, rx_data}, {1'b1, d2});
      pulse_rd();
      chk(ore == 1 && irq == 1, "R10 irq held by error", {ore, irq}, 3);
      pulse_clr();
      chk(ore == 0 && irq == 0, "R9 clear drops ore", {ore, irq}, 0);

      // R11 glitch start
      put_bit(1'b0, 1);
      put_bit(1'b1, 3 * OVS);
      chk(rdy == 0, "R11 glitch ignored", rdy, 0);
      async_frame({1'b0, 8'h5A}, 8, 1'b1);
      chk(rx_data == 8'h5A, "R11 frame after glitch", rx_data, 8'h5A);
      pulse_rd();

      // R6 synchronous framed
      mode = 2'd2; sync_frm = 1'b1;
      d = DW'($urandom);
      put_bit(1'b0, 1);
      for (int i = 0; i < DW; i++) put_bit(d[i], 1);
      put_bit(1'b1, 1);
      repeat (4) @(negedge clk);
      chk(rx_data == d && rdy == 1 && fre == 0, "R6 sync framed", rx_data, d);
      pulse_rd();

      // R7 synchronous unframed, back to back
      sync_frm = 1'b0;
      d = DW'($urandom); d2 = DW'($urandom);
      sync_bits(d);
      chk(rx_data == d && rdy == 1, "R7 unframed word 1", rx_data, d);
      pulse_rd();
      sync_bits(d2);
      chk(rx_data == d2 && fre == 0 && ore == 0, "R7 unframed word 2", rx_data, d2);
      pulse_rd();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule